// File: doc/BRIEF.md
# Serial ADC Frame Controller

This block is the host-side master of a three-wire serial link to a two-channel bipolar successive-approximation converter. One start request runs one frame. The block lowers chip select and waits a programmed setup interval. It then issues exactly sixteen serial clock periods. During those periods it shifts a 16-bit command word out on the command line and gathers the 16-bit word that the converter returns. When the frame ends it raises chip select. It splits the returned word into a leading identification bit, a channel address bit, a sign bit and a 12-bit result. A one-cycle valid strobe marks the new result.

The serial clock comes from the system clock through an even divider. The half period is given as a count of system clocks, so the duty cycle is always 50%. The setup time from select to the first clock has two programmed values, one for bipolar input ranges and one for the unipolar range. A range-type flag picks between them. After each frame a programmed quiet interval passes before chip select may fall again. All timing inputs are latched when a start request is accepted.

Top module: `adc_frame_master`

## Requirements
- R1: While reset is held low and after it is released, with no start request, cs_n_o and sclk_o are 1, and busy_o and valid_o are 0.
- R2: A start_i sampled high while busy_o is 0 lowers cs_n_o at the next clock edge. mosi_o carries cmd_i[15] from that edge on, and it changes only where sclk_o rises. At the k-th falling edge of sclk_o (k = 0..15), mosi_o equals cmd_i[15-k].
- R3: A frame has exactly 16 sclk_o periods. Each low phase and each high phase lasts H system clocks, where H is half_div_i latched at start, and a value of 0 is treated as 1. sclk_o is 1 whenever cs_n_o is 1.
- R4: The first falling edge of sclk_o comes exactly S+1 system clocks after cs_n_o falls. S is setup_uni_i when unipolar_i is 1 at start, and setup_bip_i otherwise.
- R5: Bit k of the converter word is driven after the k-th falling edge of sclk_o (bit 0 also from the fall of cs_n_o), and it is sampled where sclk_o next rises. Bit 0 becomes word bit 15, and bit 15 becomes word bit 0.
- R6: Field positions in the captured word W: chan_o = W[14], sign_o = W[13], result_o = W[12:1]. W[0] has no effect on any output.
- R7: valid_o is high for exactly one system clock per frame. It rises in the same cycle as cs_n_o, and the outputs hold their values until the next frame ends.
- R8: frame_err_o equals W[15], so it is 1 when the identification bit is not zero. The result fields are still presented in that case.
- R9: After a frame, busy_o stays high for Q+1 cycles, counted from the valid_o cycle, where Q is quiet_i latched at start. cs_n_o stays high for at least Q+2 cycles before it falls again, and for exactly Q+2 cycles when start_i is held high.
- R10: A start_i pulse while busy_o is 1 is ignored. It relatches no command or timing input and causes no extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request |
| cmd_i | input | 16 | Command word, sent MSB first |
| unipolar_i | input | 1 | 1 selects the unipolar setup count |
| half_div_i | input | DIV_W | Serial clock half period in system clocks |
| setup_bip_i | input | CNT_W | Select-to-clock setup count, bipolar ranges |
| setup_uni_i | input | CNT_W | Select-to-clock setup count, unipolar range |
| quiet_i | input | CNT_W | Quiet count between frames |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Command line |
| miso_i | input | 1 | Return data line |
| result_o | output | 12 | Conversion result, two's complement |
| chan_o | output | 1 | Channel address bit |
| sign_o | output | 1 | Sign bit |
| frame_err_o | output | 1 | Identification bit was not zero |
| valid_o | output | 1 | New result strobe |
| busy_o | output | 1 | Frame or quiet interval in progress |

## Verification
The frame is run with a set of vectors. They differ in divide ratio (including the zero and minimum settings), setup counts on both range types, quiet count, command pattern and returned word. This tells apart errors in the divider phase length, in the choice of setup count and in the bit order of either shift direction. Two returned words differ only in the trailing bit and must decode the same, which shows the field boundaries. A word with the identification bit set exercises the error flag. Directed runs hold start high to measure the exact quiet gap. Another run fires start in the middle of a frame with a different command and range, and the bench checks that neither is taken.

// File: rtl/adc_fm_pkg.sv
package adc_fm_pkg;
  localparam int FRAME_BITS = 16;
  localparam int DATA_W     = 12;
  localparam int BIDX_W     = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_QUIET} seq_st_e;

  typedef struct packed {
    logic              lead;
    logic              chan;
    logic              sign;
    logic [DATA_W-1:0] data;
    logic              spare;
  } frame_t;

  function automatic frame_t split_frame(input logic [FRAME_BITS-1:0] w);
    return frame_t'(w);
  endfunction
endpackage

// File: rtl/adc_fm_clkgen.sv
module adc_fm_clkgen
  import adc_fm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             done_o
);
  logic              active;
  logic [DIV_W-1:0]  ph;
  logic [BIDX_W-1:0] bidx;
  logic              phase_end;

  assign phase_end = active && (ph == '0);
  assign rise_o    = phase_end && !sclk_o;
  assign done_o    = phase_end && sclk_o && (bidx == BIDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= '0;
      bidx   <= '0;
      sclk_o <= 1'b1;
    end else if (launch_i) begin
      active <= 1'b1;
      sclk_o <= 1'b0;
      ph     <= half_i - DIV_W'(1);
      bidx   <= '0;
    end else if (phase_end) begin
      if (!sclk_o) begin
        sclk_o <= 1'b1;
        ph     <= half_i - DIV_W'(1);
      end else if (done_o) begin
        active <= 1'b0;
      end else begin
        sclk_o <= 1'b0;
        bidx   <= bidx + BIDX_W'(1);
        ph     <= half_i - DIV_W'(1);
      end
    end else if (active) begin
      ph <= ph - DIV_W'(1);
    end
  end
endmodule

// File: rtl/adc_fm_shifter.sv
module adc_fm_shifter
  import adc_fm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] cmd_i,
  input  logic                  rise_i,
  input  logic                  miso_i,
  output logic                  mosi_o,
  output logic [FRAME_BITS-1:0] word_o
);
  logic [FRAME_BITS-1:0] tx;

  assign mosi_o = tx[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx     <= '0;
      word_o <= '0;
    end else if (load_i) begin
      tx <= cmd_i;
    end else if (rise_i) begin
      tx     <= {tx[FRAME_BITS-2:0], 1'b0};
      word_o <= {word_o[FRAME_BITS-2:0], miso_i};
    end
  end
endmodule

// File: rtl/adc_fm_seq.sv
module adc_fm_seq
  import adc_fm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             unipolar_i,
  input  logic [CNT_W-1:0] setup_bip_i,
  input  logic [CNT_W-1:0] setup_uni_i,
  input  logic [CNT_W-1:0] quiet_i,
  input  logic             done_i,
  output logic             cs_n_o,
  output logic             busy_o,
  output logic             accept_o,
  output logic             launch_o
);
  seq_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] quiet_q;

  function automatic logic [CNT_W-1:0] pick_setup(input logic uni,
                                                  input logic [CNT_W-1:0] bip_cnt,
                                                  input logic [CNT_W-1:0] uni_cnt);
    return uni ? uni_cnt : bip_cnt;
  endfunction

  assign accept_o = (st == ST_IDLE) && start_i;
  assign launch_o = (st == ST_SETUP) && (cnt == '0);
  assign cs_n_o   = !((st == ST_SETUP) || (st == ST_SHIFT));
  assign busy_o   = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      quiet_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_i) begin
          st      <= ST_SETUP;
          cnt     <= pick_setup(unipolar_i, setup_bip_i, setup_uni_i);
          quiet_q <= quiet_i;
        end
        ST_SETUP: if (cnt == '0) st <= ST_SHIFT;
                  else cnt <= cnt - CNT_W'(1);
        ST_SHIFT: if (done_i) begin
          st  <= ST_QUIET;
          cnt <= quiet_q;
        end
        ST_QUIET: if (cnt == '0) st <= ST_IDLE;
                  else cnt <= cnt - CNT_W'(1);
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_master.sv
module adc_frame_master
  import adc_fm_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] cmd_i,
  input  logic                  unipolar_i,
  input  logic [DIV_W-1:0]      half_div_i,
  input  logic [CNT_W-1:0]      setup_bip_i,
  input  logic [CNT_W-1:0]      setup_uni_i,
  input  logic [CNT_W-1:0]      quiet_i,
  output logic                  cs_n_o,
  output logic                  sclk_o,
  output logic                  mosi_o,
  input  logic                  miso_i,
  output logic [DATA_W-1:0]     result_o,
  output logic                  chan_o,
  output logic                  sign_o,
  output logic                  frame_err_o,
  output logic                  valid_o,
  output logic                  busy_o
);
  logic                  accept_evt;
  logic                  launch_evt;
  logic                  sclk_rise;
  logic                  frame_done;
  logic [DIV_W-1:0]      half_q;
  logic [FRAME_BITS-1:0] word;
  frame_t                fields;

  function automatic logic [DIV_W-1:0] clamp_half(input logic [DIV_W-1:0] h);
    return (h == '0) ? DIV_W'(1) : h;
  endfunction

  adc_fm_seq #(.CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .unipolar_i(unipolar_i),
    .setup_bip_i(setup_bip_i), .setup_uni_i(setup_uni_i), .quiet_i(quiet_i),
    .done_i(frame_done), .cs_n_o(cs_n_o), .busy_o(busy_o),
    .accept_o(accept_evt), .launch_o(launch_evt)
  );

  adc_fm_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .launch_i(launch_evt), .half_i(half_q),
    .sclk_o(sclk_o), .rise_o(sclk_rise), .done_o(frame_done)
  );

  adc_fm_shifter shifter_i (
    .clk(clk), .rst_n(rst_n), .load_i(accept_evt), .cmd_i(cmd_i),
    .rise_i(sclk_rise), .miso_i(miso_i), .mosi_o(mosi_o), .word_o(word)
  );

  assign fields = split_frame(word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q      <= DIV_W'(1);
      result_o    <= '0;
      chan_o      <= 1'b0;
      sign_o      <= 1'b0;
      frame_err_o <= 1'b0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= frame_done;
      if (accept_evt) half_q <= clamp_half(half_div_i);
      if (frame_done) begin
        result_o    <= fields.data;
        chan_o      <= fields.chan;
        sign_o      <= fields.sign;
        frame_err_o <= fields.lead;
      end
    end
  end
endmodule

// File: rtl/adc_fm_checker.sv
module adc_fm_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic valid,
  input logic busy,
  input logic frame_done
);
  a_r1_idle_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && sclk));

  a_r3_sclk_high_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  a_r2_mosi_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> $rose(sclk));

  a_r7_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r7_valid_with_select_rise: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $rose(cs_n));

  a_r5_end_in_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (sclk && !cs_n));

  a_r9_select_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
endmodule

bind adc_frame_master adc_fm_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n_o), .sclk(sclk_o), .mosi(mosi_o),
  .valid(valid_o), .busy(busy_o), .frame_done(frame_done)
);

// File: tb/adc_frame_master_tb.sv
module adc_frame_master_tb_top;
  localparam time CLK_P = 4ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] cmd_i = '0;
  logic        unipolar_i = 1'b0;
  logic [7:0]  half_div_i = 8'd1;
  logic [7:0]  setup_bip_i = '0;
  logic [7:0]  setup_uni_i = '0;
  logic [7:0]  quiet_i = '0;
  logic        cs_n_o, sclk_o, mosi_o;
  logic        miso_i = 1'b0;
  logic [11:0] result_o;
  logic        chan_o, sign_o, frame_err_o, valid_o, busy_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_frame_master dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
    .unipolar_i(unipolar_i), .half_div_i(half_div_i), .setup_bip_i(setup_bip_i),
    .setup_uni_i(setup_uni_i), .quiet_i(quiet_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .result_o(result_o), .chan_o(chan_o),
    .sign_o(sign_o), .frame_err_o(frame_err_o), .valid_o(valid_o), .busy_o(busy_o)
  );

  // converter model: drives the return word, records the command bits
  logic [15:0] cur_word = '0;
  logic [15:0] cmd_seen = '0;
  int fidx = 0;
  always @(negedge sclk_o or negedge cs_n_o) begin
    if (sclk_o) begin
      fidx = 0;
      miso_i = cur_word[15];
    end else begin
      miso_i = cur_word[15 - fidx];
      fidx = fidx + 1;
      cmd_seen = {cmd_seen[14:0], mosi_o};
    end
  end

  // timing monitor
  int cyc = 0, t_fall = 0, t_rise = 0, t_edge = 0;
  int setup_m = 0, gap_m = 0, falls = 0, vcnt = 0, min_ph = 0, max_ph = 0;
  bit seen_rise = 0, got_first = 0;
  logic pcs = 1'b1, psclk = 1'b1;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (pcs && !cs_n_o) begin
      t_fall = cyc;
      if (seen_rise) gap_m = cyc - t_rise;
      falls = 0; vcnt = 0; got_first = 0; min_ph = 100000; max_ph = 0;
    end
    if (!pcs && cs_n_o) begin
      t_rise = cyc;
      seen_rise = 1;
    end
    if (!cs_n_o && (psclk != sclk_o)) begin
      if (psclk && !sclk_o) falls = falls + 1;
      if (!got_first) begin
        setup_m = cyc - t_fall;
        got_first = 1;
      end else begin
        if (cyc - t_edge < min_ph) min_ph = cyc - t_edge;
        if (cyc - t_edge > max_ph) max_ph = cyc - t_edge;
      end
      t_edge = cyc;
    end
    if (valid_o) vcnt = vcnt + 1;
    pcs = cs_n_o;
    psclk = sclk_o;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_valid(output bit ok);
    ok = 0;
    for (int i = 0; i < 6000; i++) begin
      if (valid_o) begin ok = 1; return; end
      step();
    end
  endtask

  task automatic check_outputs(input logic [15:0] w);
    chk("R6 chan", chan_o, (w >> 14) & 1);
    chk("R6 sign", sign_o, (w >> 13) & 1);
    chk("R5 R6 result", result_o, (w >> 1) % 4096);
    chk("R8 frame error", frame_err_o, w / 32768);
  endtask

  task automatic run_frame(input logic [15:0] cmd, input logic [15:0] w, input logic uni,
                           input logic [7:0] h, input logic [7:0] sb, input logic [7:0] su,
                           input logic [7:0] q);
    bit ok;
    int n;
    int heff = (h == 0) ? 1 : int'(h);
    cur_word = w; cmd_i = cmd; unipolar_i = uni; half_div_i = h;
    setup_bip_i = sb; setup_uni_i = su; quiet_i = q;
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    chk("R2 select low after start", cs_n_o, 0);
    wait_valid(ok);
    chk("R7 valid seen", ok, 1);
    check_outputs(w);
    n = 0;
    while (busy_o && n < 1000) begin n++; step(); end
    chk("R9 busy length", n, q + 1);
    chk("R2 command bits", cmd_seen, cmd);
    chk("R3 falling edges", falls, 16);
    chk("R3 min phase", min_ph, heff);
    chk("R3 max phase", max_ph, heff);
    chk("R4 setup", setup_m, (uni ? su : sb) + 1);
    chk("R7 valid count", vcnt, 1);
    chk("R7 outputs hold", result_o, (w >> 1) % 4096);
  endtask

  // cmd, word, uni, half, setup_bip, setup_uni, quiet
  localparam logic [64:0] VEC [6] = '{
    {16'hA5C3, 16'h3FFE, 1'b0, 8'd1, 8'd2, 8'd5, 8'd3},
    {16'h8000, 16'h0001, 1'b1, 8'd2, 8'd1, 8'd6, 8'd0},
    {16'h1234, 16'h5555, 1'b0, 8'd3, 8'd0, 8'd9, 8'd7},
    {16'hFFFF, 16'h2000, 1'b1, 8'd0, 8'd4, 8'd2, 8'd1},
    {16'h0F0F, 16'hC123, 1'b0, 8'd4, 8'd3, 8'd3, 8'd2},
    {16'h7001, 16'h5554, 1'b1, 8'd1, 8'd2, 8'd4, 8'd4}
  };

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL R7 watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit ok;
    logic [15:0] wd;
    repeat (3) step();
    // R1: outputs during reset
    chk("R1 cs_n in reset", cs_n_o, 1);
    chk("R1 sclk in reset", sclk_o, 1);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 cs_n idle", cs_n_o, 1);
    chk("R1 sclk idle", sclk_o, 1);
    chk("R1 busy idle", busy_o, 0);
    chk("R1 valid idle", valid_o, 0);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 6; i++) begin
      logic [64:0] v = VEC[i];
      run_frame(v[64:49], v[48:33], v[32], v[31:24], v[23:16], v[15:8], v[7:0]);
      repeat (2) step();
    end

    // R6: trailing bit ignored (words differ only in W[0])
    run_frame(16'h4444, 16'h6ACF, 1'b0, 8'd1, 8'd1, 8'd1, 8'd1);
    wd = {12'h0, chan_o, sign_o, frame_err_o, 1'b0};
    run_frame(16'h4444, 16'h6ACE, 1'b0, 8'd1, 8'd1, 8'd1, 8'd1);
    chk("R6 spare bit no effect result", result_o, 12'h567);
    chk("R6 spare bit no effect flags", {12'h0, chan_o, sign_o, frame_err_o, 1'b0}, wd);

    // R9: exact quiet gap with start held high
    cur_word = 16'h1111; cmd_i = 16'h9999; unipolar_i = 1'b0; half_div_i = 8'd1;
    setup_bip_i = 8'd1; quiet_i = 8'd5;
    start_i = 1'b1;
    wait_valid(ok);
    chk("R9 held start first frame", ok, 1);
    for (int i = 0; i < 200 && cs_n_o; i++) step();
    chk("R9 exact quiet gap", gap_m, 7);
    start_i = 1'b0;
    wait_valid(ok);
    check_outputs(16'h1111);
    while (busy_o) step();
    repeat (2) step();

    // R10: start while busy is ignored
    cur_word = 16'h2468; cmd_i = 16'hC3A5; unipolar_i = 1'b1; half_div_i = 8'd2;
    setup_bip_i = 8'd1; setup_uni_i = 8'd6; quiet_i = 8'd2;
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    repeat (20) step();
    cmd_i = 16'h0000; unipolar_i = 1'b0; half_div_i = 8'd5; quiet_i = 8'd9;
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    wait_valid(ok);
    check_outputs(16'h2468);
    while (busy_o) step();
    chk("R10 command not relatched", cmd_seen, 16'hC3A5);
    chk("R10 setup not relatched", setup_m, 7);
    chk("R10 divider not relatched", max_ph, 2);
    chk("R10 single valid", vcnt, 1);
    ok = 1;
    for (int i = 0; i < 30; i++) begin
      if (!cs_n_o || busy_o) ok = 0;
      step();
    end
    chk("R10 no extra frame", ok, 1);

    finish_run();
  end
endmodule